// File: doc/BRIEF.md
# Memory Status Polling Engine

This block waits for a serial memory to reach a wanted state. It reads the memory's status over and over until a masked comparison succeeds, or until a time budget runs out. A host loads a job and pulses `go`. The job holds the operation word to issue, the status width (one or two bytes), a 16-bit mask, a 16-bit match value, an initial delay and a polling interval in microseconds, and a timeout in milliseconds. The engine waits out the initial delay. It then hands the operation to a downstream sequencer with a one-cycle start pulse, gathers the status bytes that come back, and compares them when the sequencer signals completion.

A microsecond tick comes from the system clock through a parameterised divider. Each delay restarts its own divider, so a delay always spans whole microseconds from the moment it is loaded. The timeout runs on a second divider. That divider is armed when the first read is issued, and the timeout is evaluated each time a read completes. Either outcome gives a one-cycle `fin` pulse. The success and timeout flags and the last status value stay valid after that pulse. An `abort` input drops the engine back to idle on the next clock edge and reports nothing.

Top module: `stpoll_engine`

## Requirements
- R1: When a completed read gives status S with (S & mask) == match, the engine pulses `fin` with `fin_ok`=1, `fin_tmo`=0, and `last_status` equal to S.
- R2: A completed read that does not match, before the timeout has expired, leads to another read. The engine never reports success before the first matching read.
- R3: The first `seq_start` pulse appears between init_us*US_DIV+1 and init_us*US_DIV+3 clock cycles after the cycle in which `go` is presented.
- R4: After a non-matching read that has not timed out, the next `seq_start` appears between ivl_us*US_DIV+1 and ivl_us*US_DIV+3 cycles after the cycle in which `seq_done` was high.
- R5: The timeout window is tmo_ms*US_PER_MS*US_DIV cycles, counted from the first `seq_start`. A non-matching read that completes after the window ends the job with `fin_tmo`=1 and `fin_ok`=0. A read that completes well inside the window does not end the job. With tmo_ms=0, the first non-matching read times out.
- R6: On a timeout, `last_status` equals the status of the last read that completed.
- R7: With `two_in`=0, one status byte is taken and zero-extended: `last_status` = {8'h00, byte}.
- R8: With `two_in`=1, the first received byte forms bits 15:8 and the second forms bits 7:0. Any byte that arrives after the expected count is ignored.
- R9: When `abort` is high at a clock edge, `busy` is low after that edge. No `fin` pulse follows, and no further `seq_start` is issued.
- R10: A `go` pulse while `busy` is high is ignored. The running job continues with its original parameters and is not restarted.
- R11: `fin` is high for exactly one cycle. `fin_ok` and `fin_tmo` are mutually exclusive and keep their values after the pulse until the next accepted `go`.
- R12: After reset, `busy`, `fin`, `fin_ok`, `fin_tmo` and `seq_start` are 0 and `last_status` is 0.
- R13: `seq_start` is a single-cycle pulse per read. During it, `seq_op` and `seq_two` carry the `op_in` and `two_in` values captured at the accepted `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a polling job (taken only when idle) |
| abort | input | 1 | Return to idle, no result |
| op_in | input | OP_W | Operation word handed to the sequencer |
| two_in | input | 1 | Status width: 0 = one byte, 1 = two bytes |
| mask_in | input | 16 | Status compare mask |
| match_in | input | 16 | Status compare value |
| init_us | input | DLY_W | Delay before the first read, microseconds |
| ivl_us | input | DLY_W | Gap between reads, microseconds |
| tmo_ms | input | TMO_W | Timeout, milliseconds |
| seq_start | output | 1 | One-cycle request to the sequencer |
| seq_op | output | OP_W | Captured operation word |
| seq_two | output | 1 | Captured status width |
| seq_done | input | 1 | Sequencer finished the read |
| seq_vld | input | 1 | A status byte is present on seq_byte |
| seq_byte | input | 8 | Status byte from the sequencer |
| busy | output | 1 | A job is in progress |
| fin | output | 1 | One-cycle completion pulse |
| fin_ok | output | 1 | Job ended on a match |
| fin_tmo | output | 1 | Job ended on timeout |
| last_status | output | 16 | Status of the last completed read |

## Verification
Seeded random jobs draw random masks, status widths, delays and sequences of one to six reads, with only the last read matching. These jobs separate a correct masked compare from one that ignores the mask or stops early, and they check read count and spacing against the delay and interval settings. Directed jobs cover the rest. A one-byte read uses a mask on the upper half, which exposes a missing zero-extension. A two-byte read with a trailing extra byte exposes reversed byte order or over-collection. Never-matching jobs check timeout placement and the reported status, including a zero timeout. Aborts are placed in the delay phase and in the read phase, and a second `go` is sent mid-job with a mask that would match at once if adopted.

// File: rtl/stpoll_pkg.sv
// Shared types and helpers for the status polling engine.
// Assumes status values are at most two bytes wide.
package stpoll_pkg;

    localparam int STAT_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_HOLD  = 2'd1,
        PS_ISSUE = 2'd2,
        PS_WAIT  = 2'd3
    } poll_state_t;

    // True when the masked status equals the wanted value.
    function automatic logic stat_hit(input logic [STAT_W-1:0] s,
                                      input logic [STAT_W-1:0] m,
                                      input logic [STAT_W-1:0] v);
        return (s & m) == v;
    endfunction

endpackage

// File: rtl/stpoll_tick.sv
// Microsecond tick generator.
// Emits one-cycle tick every DIV cycles while run is high; restart puts
// the phase back to zero so the next tick is DIV cycles away.
// Assumes DIV >= 1.
module stpoll_tick #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_pass
            // Every enabled cycle is a full microsecond.
            assign tick = run && !restart;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            logic          wrap;

            assign wrap = (cnt_q == CW'(DIV - 1));
            assign tick = run && !restart && wrap;

            // Phase counter, cleared on restart or when stopped.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (restart || !run) begin
                    cnt_q <= '0;
                end else if (wrap) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= CW'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/stpoll_downcnt.sv
// Loadable down counter that stops at zero.
// load has priority over tick; zero reports an exhausted count.
module stpoll_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    assign zero = (cnt_q == '0);

    // Count down one per tick, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3/R4/R5: an exhausted count never wraps around.
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/stpoll_collect.sv
// Status byte collector.
// Shifts in bytes MSB-first up to the expected count (one or two);
// later bytes are dropped. value_nx shows the value including a byte
// arriving this cycle so the caller can compare on the same cycle.
module stpoll_collect #(
    parameter int BW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          two,
    input  logic          vld,
    input  logic [BW-1:0] din,
    output logic [SW-1:0] value_nx
);
    logic [1:0]    cnt_q;
    logic [SW-1:0] val_q;
    logic          room;
    logic          take;

    assign room     = cnt_q < (two ? 2'd2 : 2'd1);
    assign take     = vld && room;
    assign value_nx = take ? {val_q[SW-BW-1:0], din} : val_q;

    // Accumulate accepted bytes; clear at each new read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            val_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            val_q <= '0;
        end else begin
            val_q <= value_nx;
            if (take) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 2'd2);
    assert_extra_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && vld && !room) |=> $stable(val_q));

endmodule

// File: rtl/stpoll_engine.sv
// Status polling engine top.
// Waits an initial delay, issues a status read through a start/done
// handshake, compares (status & mask) with match, and repeats at a fixed
// interval until a hit or until the timeout, armed at the first read,
// has expired when a read completes. Abort returns to idle silently.
// Assumes the sequencer delivers status bytes before or with seq_done.
module stpoll_engine
    import stpoll_pkg::*;
#(
    parameter int OP_W      = 32,
    parameter int DLY_W     = 16,
    parameter int TMO_W     = 16,
    parameter int US_DIV    = 250,
    parameter int US_PER_MS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              abort,
    input  logic [OP_W-1:0]   op_in,
    input  logic              two_in,
    input  logic [15:0]       mask_in,
    input  logic [15:0]       match_in,
    input  logic [DLY_W-1:0]  init_us,
    input  logic [DLY_W-1:0]  ivl_us,
    input  logic [TMO_W-1:0]  tmo_ms,
    output logic              seq_start,
    output logic [OP_W-1:0]   seq_op,
    output logic              seq_two,
    input  logic              seq_done,
    input  logic              seq_vld,
    input  logic [7:0]        seq_byte,
    output logic              busy,
    output logic              fin,
    output logic              fin_ok,
    output logic              fin_tmo,
    output logic [15:0]       last_status
);
    localparam int TUW = TMO_W + $clog2(US_PER_MS + 1);

    poll_state_t        st_q, st_nx;
    logic [OP_W-1:0]    op_q;
    logic               two_q;
    logic [STAT_W-1:0]  mask_q, match_q;
    logic [DLY_W-1:0]   ivl_q;
    logic [TMO_W-1:0]   tms_q;
    logic               armed_q;
    logic               fin_q, ok_q, tmo_q;
    logic [STAT_W-1:0]  last_q;

    logic               accept, rd_done, hit, expired, arm_first;
    logic               dly_load, dly_tick, dly_zero;
    logic [DLY_W-1:0]   dly_val;
    logic               to_tick, to_zero;
    logic [TUW-1:0]     to_val;
    logic [STAT_W-1:0]  stat_now;

    assign accept    = (st_q == PS_IDLE) && go && !abort;
    assign rd_done   = (st_q == PS_WAIT) && seq_done && !abort;
    assign hit       = stat_hit(stat_now, mask_q, match_q);
    assign expired   = armed_q && to_zero;
    assign arm_first = (st_q == PS_ISSUE) && !armed_q && !abort;
    assign to_val    = TUW'(tms_q) * TUW'(US_PER_MS);

    // Delay timer: initial delay and polling interval.
    stpoll_tick #(.DIV(US_DIV)) u_dly_tick (
        .clk(clk), .rst_n(rst_n), .restart(dly_load),
        .run(st_q != PS_IDLE), .tick(dly_tick)
    );
    stpoll_downcnt #(.W(DLY_W)) u_dly_cnt (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val),
        .tick(dly_tick), .zero(dly_zero)
    );

    // Timeout timer: armed at the first issued read.
    stpoll_tick #(.DIV(US_DIV)) u_to_tick (
        .clk(clk), .rst_n(rst_n), .restart(arm_first),
        .run(armed_q), .tick(to_tick)
    );
    stpoll_downcnt #(.W(TUW)) u_to_cnt (
        .clk(clk), .rst_n(rst_n), .load(arm_first), .load_val(to_val),
        .tick(to_tick), .zero(to_zero)
    );

    // Status byte gathering for the current read.
    stpoll_collect #(.BW(BYTE_W), .SW(STAT_W)) u_collect (
        .clk(clk), .rst_n(rst_n), .clear(st_q == PS_ISSUE), .two(two_q),
        .vld(seq_vld && (st_q == PS_WAIT)), .din(seq_byte),
        .value_nx(stat_now)
    );

    // Next-state and delay-load decisions.
    always_comb begin
        st_nx    = st_q;
        dly_load = 1'b0;
        dly_val  = '0;
        if (abort) begin
            st_nx = PS_IDLE;
        end else begin
            unique case (st_q)
                PS_IDLE: if (go) begin
                    st_nx    = PS_HOLD;
                    dly_load = 1'b1;
                    dly_val  = init_us;
                end
                PS_HOLD: if (dly_zero) st_nx = PS_ISSUE;
                PS_ISSUE: st_nx = PS_WAIT;
                PS_WAIT: if (seq_done) begin
                    if (hit || expired) begin
                        st_nx = PS_IDLE;
                    end else begin
                        st_nx    = PS_HOLD;
                        dly_load = 1'b1;
                        dly_val  = ivl_q;
                    end
                end
                default: st_nx = PS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PS_IDLE;
        else        st_q <= st_nx;
    end

    // Capture job parameters when a job is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            two_q   <= 1'b0;
            mask_q  <= '0;
            match_q <= '0;
            ivl_q   <= '0;
            tms_q   <= '0;
        end else if (accept) begin
            op_q    <= op_in;
            two_q   <= two_in;
            mask_q  <= mask_in;
            match_q <= match_in;
            ivl_q   <= ivl_us;
            tms_q   <= tmo_ms;
        end
    end

    // Timeout arming flag.
    always_ff @(posedge clk) begin
        if (!rst_n)               armed_q <= 1'b0;
        else if (abort || accept) armed_q <= 1'b0;
        else if (arm_first)       armed_q <= 1'b1;
    end

    // Result flags and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q <= 1'b0;
            ok_q  <= 1'b0;
            tmo_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (abort || accept) begin
                ok_q  <= 1'b0;
                tmo_q <= 1'b0;
            end else if (rd_done && (hit || expired)) begin
                fin_q <= 1'b1;
                ok_q  <= hit;
                tmo_q <= !hit;
            end
        end
    end

    // Last completed status value.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= '0;
        else if (rd_done) last_q <= stat_now;
    end

    assign seq_start   = (st_q == PS_ISSUE);
    assign seq_op      = op_q;
    assign seq_two     = two_q;
    assign busy        = (st_q != PS_IDLE);
    assign fin         = fin_q;
    assign fin_ok      = ok_q;
    assign fin_tmo     = tmo_q;
    assign last_status = last_q;

    assert_fin_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> !fin_q);
    assert_fin_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> ($countones({ok_q, tmo_q}) == 1));
    assert_ok_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q && ok_q) |-> ((last_q & mask_q) == match_q));
    assert_tmo_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q && tmo_q) |-> armed_q);
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !fin_q));
    assert_start_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

endmodule

// File: tb/test_stpoll_engine.sv
module test_stpoll_engine;
    localparam int DIV = 3;
    localparam int PMS = 10;
    localparam int OPW = 16;
    localparam int DW  = 8;
    localparam int TW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic           go = 0, abort = 0, two_in = 0;
    logic [OPW-1:0] op_in = '0;
    logic [15:0]    mask_in = '0, match_in = '0;
    logic [DW-1:0]  init_us = '0, ivl_us = '0;
    logic [TW-1:0]  tmo_ms = '0;
    logic           seq_start, seq_two, busy, fin, fin_ok, fin_tmo;
    logic [OPW-1:0] seq_op;
    logic           seq_done = 0, seq_vld = 0;
    logic [7:0]     seq_byte = '0;
    logic [15:0]    last_status;

    stpoll_engine #(.OP_W(OPW), .DLY_W(DW), .TMO_W(TW), .US_DIV(DIV), .US_PER_MS(PMS))
    i_stpoll_engine (
        .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .op_in(op_in),
        .two_in(two_in), .mask_in(mask_in), .match_in(match_in),
        .init_us(init_us), .ivl_us(ivl_us), .tmo_ms(tmo_ms),
        .seq_start(seq_start), .seq_op(seq_op), .seq_two(seq_two),
        .seq_done(seq_done), .seq_vld(seq_vld), .seq_byte(seq_byte),
        .busy(busy), .fin(fin), .fin_ok(fin_ok), .fin_tmo(fin_tmo),
        .last_status(last_status)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    bit all_done = 0;

    logic [15:0] rsp_stat [0:15];
    int          rsp_n = 1, rsp_idx = 0, rsp_lat = 2;
    bit          rsp_extra = 0, exp_two = 0;
    logic [OPW-1:0] exp_op = '0;
    int          st_cyc [0:63];
    int          dn_cyc [0:63];
    int          n_st = 0, n_dn = 0, go_cyc = 0, cur_init = 0, cur_ivl = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] view(input logic [15:0] s, input bit two);
        return two ? s : {8'h00, s[7:0]};
    endfunction

    // Sequencer model: answers each start with bytes then done.
    initial begin
        forever begin
            @(negedge clk);
            if (seq_start) begin
                logic [15:0] s;
                if (n_st < 64) st_cyc[n_st] = cyc;
                n_st++;
                chk(seq_op == exp_op && seq_two == exp_two, "R13 seq_op/seq_two",
                    {15'd0, seq_two, seq_op}, {15'd0, exp_two, exp_op});
                s = rsp_stat[(rsp_idx < rsp_n) ? rsp_idx : rsp_n - 1];
                rsp_idx++;
                repeat (rsp_lat) @(negedge clk);
                seq_vld = 1;
                seq_byte = exp_two ? s[15:8] : s[7:0];
                if (exp_two) begin
                    @(negedge clk);
                    seq_byte = s[7:0];
                end
                if (rsp_extra) begin
                    @(negedge clk);
                    seq_byte = 8'h5A;
                end
                @(negedge clk);
                seq_vld = 0;
                seq_done = 1;
                if (n_dn < 64) dn_cyc[n_dn] = cyc;
                n_dn++;
                @(negedge clk);
                seq_done = 0;
            end
        end
    end

    task automatic start_job(input int init, input int ivl, input int tms, input bit two,
                             input bit extra, input logic [15:0] m, input logic [15:0] v,
                             input logic [OPW-1:0] op);
        @(negedge clk);
        init_us = DW'(init); ivl_us = DW'(ivl); tmo_ms = TW'(tms);
        two_in = two; mask_in = m; match_in = v; op_in = op;
        exp_two = two; exp_op = op; rsp_extra = extra;
        cur_init = init; cur_ivl = ivl;
        rsp_idx = 0; n_st = 0; n_dn = 0;
        go = 1; go_cyc = cyc;
        @(negedge clk);
        go = 0;
    endtask

    task automatic wait_fin(input int lim, output bit got);
        got = 0;
        for (int i = 0; i < lim; i++) begin
            if (fin) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic check_timing();
        if (n_st > 0)
            chk(st_cyc[0] - go_cyc >= cur_init*DIV+1 && st_cyc[0] - go_cyc <= cur_init*DIV+3,
                "R3 initial delay", st_cyc[0] - go_cyc, cur_init*DIV+2);
        for (int j = 1; j < n_st && j < 64; j++)
            chk(st_cyc[j] - dn_cyc[j-1] >= cur_ivl*DIV+1 && st_cyc[j] - dn_cyc[j-1] <= cur_ivl*DIV+3,
                "R4 interval", st_cyc[j] - dn_cyc[j-1], cur_ivl*DIV+2);
    endtask

    // Job expected to end on the k-th read matching.
    task automatic expect_hit(input int k, input logic [15:0] exp_last, input string tag);
        bit got;
        wait_fin(20000, got);
        chk(got, {tag, " fin seen"}, 0, 1);
        chk(fin_ok == 1 && fin_tmo == 0, {tag, " R1 ok flag"}, {fin_ok, fin_tmo}, 2'b10);
        chk(last_status == exp_last, {tag, " R1 last_status"}, last_status, exp_last);
        chk(n_st == k, {tag, " R2 read count"}, n_st, k);
        check_timing();
        @(negedge clk);
        chk(fin == 0 && fin_ok == 1 && last_status == exp_last, "R11 pulse/held",
            {fin, fin_ok}, 2'b01);
    endtask

    initial begin
        bit got, seen;
        void'($urandom(32'd4242));
        // R12 reset state
        repeat (3) @(negedge clk);
        chk(busy == 0 && fin == 0 && fin_ok == 0 && fin_tmo == 0 && seq_start == 0,
            "R12 reset flags", {busy, fin, fin_ok, fin_tmo, seq_start}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && seq_start == 0 && last_status == 0, "R12 after release",
            last_status, 0);

        // R7 one-byte zero-extension: upper mask bits must see zero.
        rsp_stat[0] = 16'hFFFF; rsp_n = 1;
        start_job(2, 1, 50, 0, 0, 16'hFF00, 16'h0000, 16'h0A05);
        expect_hit(1, 16'h00FF, "R7");

        // R8 two-byte ordering with a surplus byte.
        rsp_stat[0] = 16'h1234; rsp_n = 1;
        start_job(0, 0, 50, 1, 1, 16'hFFFF, 16'h1234, 16'h0B06);
        expect_hit(1, 16'h1234, "R8");

        // Seeded random jobs: only the final read matches.
        for (int it = 0; it < 24; it++) begin
            int k;
            bit two;
            logic [15:0] m, v, sf;
            k = 1 + int'($urandom_range(0, 5));
            two = 1'($urandom_range(0, 1));
            m = 16'($urandom) | 16'h0001;
            sf = 16'($urandom);
            v = view(sf, two) & m;
            for (int j = 0; j < k - 1; j++) begin
                logic [15:0] s;
                s = 16'($urandom);
                if ((view(s, two) & m) == v) s = s ^ 16'h0001;
                rsp_stat[j] = s;
            end
            rsp_stat[k-1] = sf;
            rsp_n = k;
            start_job(int'($urandom_range(0, 6)), int'($urandom_range(0, 5)), 200, two,
                      1'($urandom_range(0, 1)), m, v, 16'($urandom));
            expect_hit(k, view(sf, two), "R1 random");
        end

        // R5/R6 timeout with never-matching statuses.
        for (int j = 0; j < 16; j++) rsp_stat[j] = 16'(j + 1);
        rsp_n = 16;
        start_job(1, 3, 2, 1, 0, 16'h8000, 16'h8000, 16'h0C07);
        wait_fin(5000, got);
        chk(got && fin_tmo == 1 && fin_ok == 0, "R5 timeout flag", {fin_ok, fin_tmo}, 2'b01);
        chk(last_status == rsp_stat[(n_dn - 1) & 15], "R6 last status on timeout",
            last_status, rsp_stat[(n_dn - 1) & 15]);
        chk(n_dn >= 2 && dn_cyc[n_dn-1] - st_cyc[0] >= 2*PMS*DIV - 1, "R5 not early",
            dn_cyc[n_dn-1] - st_cyc[0], 2*PMS*DIV);
        chk(n_dn >= 2 && dn_cyc[n_dn-2] - st_cyc[0] <= 2*PMS*DIV + 2, "R5 not late",
            dn_cyc[n_dn-2] - st_cyc[0], 2*PMS*DIV);
        chk(n_st == n_dn, "R2 reads repeat until timeout", n_st, n_dn);
        @(negedge clk);
        chk(fin == 0 && fin_tmo == 1, "R11 timeout held", {fin, fin_tmo}, 2'b01);

        // R5 zero timeout: one read, then timeout.
        rsp_stat[0] = 16'h0042; rsp_n = 1;
        start_job(0, 0, 0, 0, 0, 16'h00FF, 16'h0001, 16'h0D08);
        wait_fin(500, got);
        chk(got && fin_tmo == 1 && n_st == 1, "R5 zero timeout", n_st, 1);
        chk(last_status == 16'h0042, "R6 zero timeout status", last_status, 16'h0042);

        // R9 abort during the initial delay.
        start_job(20, 0, 50, 0, 0, 16'h0001, 16'h0001, 16'h0E09);
        repeat (5) @(negedge clk);
        abort = 1;
        @(negedge clk);
        abort = 0;
        chk(busy == 0, "R9 idle after abort (delay)", busy, 0);
        seen = 0;
        for (int i = 0; i < 90; i++) begin
            if (fin || seq_start) seen = 1;
            @(negedge clk);
        end
        chk(!seen && n_st == 0, "R9 nothing after abort (delay)", n_st, 0);

        // R9 abort while a read is outstanding.
        rsp_lat = 10; rsp_stat[0] = 16'h0001; rsp_n = 1;
        start_job(0, 0, 50, 0, 0, 16'h0001, 16'h0001, 16'h0F0A);
        for (int i = 0; i < 20 && n_st == 0; i++) @(negedge clk);
        abort = 1;
        @(negedge clk);
        abort = 0;
        chk(busy == 0, "R9 idle after abort (read)", busy, 0);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (fin) seen = 1;
            @(negedge clk);
        end
        chk(!seen && n_st == 1 && fin_ok == 0, "R9 no result after abort", {seen, fin_ok}, 0);
        rsp_lat = 2;

        // R10 go while busy must not change mask/match or restart.
        rsp_stat[0] = 16'h0011; rsp_stat[1] = 16'h0022; rsp_stat[2] = 16'h00C3; rsp_n = 3;
        start_job(2, 4, 100, 0, 0, 16'hFFFF, 16'h00C3, 16'h1111);
        for (int i = 0; i < 40 && n_st == 0; i++) @(negedge clk);
        mask_in = 16'h0000; match_in = 16'h0000; go = 1;
        @(negedge clk);
        go = 0;
        expect_hit(3, 16'h00C3, "R10");

        all_done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R2 act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule